// File: doc/BRIEF.md
# Mode-Locked Memory-Mapped Address Decoder

This block sits between a small 32-bit processor's bus and the devices it reaches. Each access presents an address, a write enable, write data and a read strobe. From the top address bits the block picks one of three destinations: program ROM, RAM, or one of several memory-mapped cores. It raises a one-hot select line for the chosen destination and returns read data one cycle later. It also flags any access that is illegal.

Two of the cores are modelled inside the block. The first is a secret-key store, in which each word can be read only once per reset. The second is a system-control core, which holds the identity words, the application address and size registers, the compound identifier words, and a mode-switch register.

After reset the block is in loader mode. Writing a non-zero value to the mode-switch register moves it into application mode. Only a reset leaves application mode. In application mode the key store disappears from the map, and the loader-writable registers become read-only.

Top module: `mmio_mode_decoder`

## Requirements
- R1: Address bits [31:30] pick the region. 00 is ROM (select bit 0) and 01 is RAM (select bit 1). 11 is the memory-mapped space. 10 is reserved: an access there raises no select, returns read data 0 and sets the error flag.
- R2: In the memory-mapped space, the top byte picks the core and raises one select bit. The mapping is 0xC0 random source (bit 2), 0xC1 timer (bit 3), 0xC2 key store (bit 4), 0xC3 serial port (bit 5), 0xC4 touch sensor (bit 6) and 0xFF system control (bit 7). Any other top byte is an error with no select. Select lines follow the access in the same cycle.
- R3: Read data is registered. The cycle after a legal read it holds the selected source's word; external sources come from `ext_rdata` slices 0 to 5, in the order ROM, RAM, random, timer, serial, touch. It is 0 after any cycle with no read or with an error.
- R4: System control returns 0x6D746131 at offset 0x0, 0x6D6B6466 at offset 0x4 and 1 at offset 0x8. Writes to these offsets are ignored and flagged.
- R5: Writing a non-zero value to system offset 0x10 in loader mode sets `app_mode` from the next cycle on. Writing zero changes nothing and is not flagged. In application mode any write there is ignored and flagged. Reading offset 0x10 is always flagged.
- R6: The application address register (system offset 0x14) and the application size register (offset 0x18) are read/write in loader mode. In application mode they are read-only: a write is ignored and flagged. When a read and a write hit the same register in one cycle, the read returns the old value.
- R7: The compound identifier words at system offsets 0x40 + 4*i, for i from 0 to CDI_WORDS-1, follow the same rule as R6.
- R8: In loader mode, key word i sits at key-core offset 4*i. It equals KEY_SEED XOR (i * 0x9E3779B9) modulo 2^32. The first read after reset returns that value, and later reads of the same word return 0. Writes to the key core, and offsets at or beyond 4*KEY_WORDS, are flagged and change nothing.
- R9: In application mode the key core is hidden. Accesses raise no select, read as 0, are flagged, and consume no key word.
- R10: A memory-mapped access with address bits [1:0] not zero is flagged. It raises no select and has no side effect: no register write, no mode change, no key word consumed.
- R11: `access_err` is registered. It is high for exactly the one cycle that follows a flagged access and low otherwise.
- R12: A synchronous active-high reset returns the block to loader mode, zeroes all registers and restores every key word to readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| ext_rdata | input | 192 | Read words of the six external destinations, 32 bits each |
| sel | output | 8 | One-hot destination select, combinational |
| rd_data | output | 32 | Registered read data |
| access_err | output | 1 | Registered error flag |
| app_mode | output | 1 | 1 in application mode |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a read and a write to one register. The bench raises both strobes on the application size register in loader mode, then expects the old value on the read port and the new value on the following read. The second pair is the permission check and the side effect it guards. The bench sends the mode-switch write misaligned, and a key read misaligned, in a cycle that carries an error. It then checks that the mode bit stays low and that the key word can still be read afterwards.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int DW     = 32;
    localparam int NSEL   = 8;
    localparam int EXT_N  = 6;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'b00,
        RGN_RAM  = 2'b01,
        RGN_RSVD = 2'b10,
        RGN_MMIO = 2'b11
    } region_e;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_ROM,
        TGT_RAM,
        TGT_RNG,
        TGT_TIMER,
        TGT_KEY,
        TGT_UART,
        TGT_TOUCH,
        TGT_SYS
    } tgt_e;

    typedef struct packed {
        tgt_e        tgt;
        logic        bad;
        logic [23:0] off;
    } dec_t;

    localparam logic [7:0] CODE_RNG   = 8'hC0;
    localparam logic [7:0] CODE_TIMER = 8'hC1;
    localparam logic [7:0] CODE_KEY   = 8'hC2;
    localparam logic [7:0] CODE_UART  = 8'hC3;
    localparam logic [7:0] CODE_TOUCH = 8'hC4;
    localparam logic [7:0] CODE_SYS   = 8'hFF;

    localparam logic [23:0] OFF_ID0    = 24'h00;
    localparam logic [23:0] OFF_ID1    = 24'h04;
    localparam logic [23:0] OFF_VER    = 24'h08;
    localparam logic [23:0] OFF_SWITCH = 24'h10;
    localparam logic [23:0] OFF_ADDR   = 24'h14;
    localparam logic [23:0] OFF_SIZE   = 24'h18;
    localparam logic [23:0] OFF_CDI    = 24'h40;

    localparam logic [DW-1:0] ID_WORD0 = 32'h6D74_6131;
    localparam logic [DW-1:0] ID_WORD1 = 32'h6D6B_6466;
    localparam logic [DW-1:0] ID_VER   = 32'h0000_0001;

    localparam logic [DW-1:0] KEY_STEP = 32'h9E37_79B9;

    function automatic logic [DW-1:0] key_word(input logic [DW-1:0] seed,
                                               input int unsigned  idx);
        logic [DW-1:0] prod;
        prod = DW'(idx) * KEY_STEP;
        return seed ^ prod;
    endfunction

    // Target that owns select bit i
    function automatic tgt_e sel_target(input int unsigned i);
        case (i)
            0:       return TGT_ROM;
            1:       return TGT_RAM;
            2:       return TGT_RNG;
            3:       return TGT_TIMER;
            4:       return TGT_KEY;
            5:       return TGT_UART;
            6:       return TGT_TOUCH;
            7:       return TGT_SYS;
            default: return TGT_NONE;
        endcase
    endfunction

    // Target whose word arrives on external read slice i
    function automatic tgt_e ext_target(input int unsigned i);
        case (i)
            0:       return TGT_ROM;
            1:       return TGT_RAM;
            2:       return TGT_RNG;
            3:       return TGT_TIMER;
            4:       return TGT_UART;
            5:       return TGT_TOUCH;
            default: return TGT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
    import mmio_pkg::*;
(
    input  logic [31:0] addr,
    input  logic        app_mode,
    output dec_t        dec
);
    region_e rgn;

    always_comb begin
        rgn     = region_e'(addr[31:30]);
        dec.off = addr[23:0];
        dec.tgt = TGT_NONE;
        dec.bad = 1'b0;
        case (rgn)
            RGN_ROM:  dec.tgt = TGT_ROM;
            RGN_RAM:  dec.tgt = TGT_RAM;
            RGN_RSVD: dec.bad = 1'b1;
            RGN_MMIO: begin
                case (addr[31:24])
                    CODE_RNG:   dec.tgt = TGT_RNG;
                    CODE_TIMER: dec.tgt = TGT_TIMER;
                    CODE_KEY:   dec.tgt = TGT_KEY;
                    CODE_UART:  dec.tgt = TGT_UART;
                    CODE_TOUCH: dec.tgt = TGT_TOUCH;
                    CODE_SYS:   dec.tgt = TGT_SYS;
                    default:    dec.bad = 1'b1;
                endcase
                if (addr[1:0] != 2'b00) begin
                    dec.bad = 1'b1;
                end
                if (dec.tgt == TGT_KEY && app_mode) begin
                    dec.bad = 1'b1;
                end
            end
            default: dec.bad = 1'b1;
        endcase
        if (dec.bad) begin
            dec.tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/mmio_key_store.sv
module mmio_key_store
    import mmio_pkg::*;
#(
    parameter int              KEY_WORDS = 8,
    parameter logic [DW-1:0]   KEY_SEED  = 32'h5A5A_C3C3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [23:0]   off,
    input  logic          take,
    output logic          in_range,
    output logic [DW-1:0] rdata
);
    localparam int IDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
    localparam logic [23:0] SPAN = 24'(KEY_WORDS * 4);

    logic [KEY_WORDS-1:0] used_q;
    logic [DW-1:0]        words [KEY_WORDS];
    logic [IDX_W-1:0]     idx;

    genvar g;
    generate
        for (g = 0; g < KEY_WORDS; g++) begin : g_word
            assign words[g] = key_word(KEY_SEED, g);
        end
    endgenerate

    always_comb begin
        in_range = (off < SPAN);
        idx      = off[IDX_W+1:2];
        rdata    = '0;
        if (in_range && !used_q[idx]) begin
            rdata = words[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
        end else if (take && in_range) begin
            used_q[idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/mmio_sysctl.sv
module mmio_sysctl
    import mmio_pkg::*;
#(
    parameter int CDI_WORDS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [23:0]   off,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          app_mode,
    output logic [DW-1:0] rdata,
    output logic          err
);
    localparam int CIDX_W = (CDI_WORDS > 1) ? $clog2(CDI_WORDS) : 1;
    localparam logic [23:0] CDI_END = OFF_CDI + 24'(CDI_WORDS * 4);

    logic          mode_q;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] size_q;
    logic [DW-1:0] cdi_q [CDI_WORDS];
    logic          cdi_hit;
    logic [23:0]   cdi_rel;
    logic [CIDX_W-1:0] cidx;
    logic          commit;

    always_comb begin
        cdi_hit = (off >= OFF_CDI) && (off < CDI_END);
        cdi_rel = off - OFF_CDI;
        cidx    = cdi_rel[CIDX_W+1:2];
        rdata   = '0;
        err     = 1'b0;
        if (rd || wr) begin
            if (off == OFF_ID0 || off == OFF_ID1 || off == OFF_VER) begin
                rdata = (off == OFF_ID0) ? ID_WORD0 :
                        (off == OFF_ID1) ? ID_WORD1 : ID_VER;
                err   = wr;
            end else if (off == OFF_SWITCH) begin
                err = rd || mode_q;
            end else if (off == OFF_ADDR) begin
                rdata = addr_q;
                err   = wr && mode_q;
            end else if (off == OFF_SIZE) begin
                rdata = size_q;
                err   = wr && mode_q;
            end else if (cdi_hit) begin
                rdata = cdi_q[cidx];
                err   = wr && mode_q;
            end else begin
                err = 1'b1;
            end
        end
        commit = wr && !err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            addr_q <= '0;
            size_q <= '0;
            for (int i = 0; i < CDI_WORDS; i++) begin
                cdi_q[i] <= '0;
            end
        end else if (commit) begin
            if (off == OFF_SWITCH && wdata != '0) begin
                mode_q <= 1'b1;
            end
            if (off == OFF_ADDR) begin
                addr_q <= wdata;
            end
            if (off == OFF_SIZE) begin
                size_q <= wdata;
            end
            if (cdi_hit) begin
                cdi_q[cidx] <= wdata;
            end
        end
    end

    assign app_mode = mode_q;

endmodule

// File: rtl/mmio_mode_decoder.sv
module mmio_mode_decoder
    import mmio_pkg::*;
#(
    parameter int            KEY_WORDS = 8,
    parameter int            CDI_WORDS = 8,
    parameter logic [31:0]   KEY_SEED  = 32'h5A5A_C3C3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [31:0]           bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_re,
    input  logic [EXT_N*DW-1:0]   ext_rdata,
    output logic [NSEL-1:0]       sel,
    output logic [31:0]           rd_data,
    output logic                  access_err,
    output logic                  app_mode
);
    dec_t          dec;
    logic          acc;
    logic          err_now;
    logic          key_in_range;
    logic [DW-1:0] key_rdata;
    logic          key_take;
    logic          sys_rd;
    logic          sys_wr;
    logic [DW-1:0] sys_rdata;
    logic          sys_err;
    logic [DW-1:0] ext_word [EXT_N];
    logic [EXT_N-1:0] ext_hit;
    logic [DW-1:0] rd_next;
    logic [DW-1:0] rd_q;
    logic          err_q;

    mmio_addr_decode u_dec (
        .addr     (bus_addr),
        .app_mode (app_mode),
        .dec      (dec)
    );

    assign acc      = bus_re || bus_we;
    assign key_take = bus_re && !bus_we && (dec.tgt == TGT_KEY);
    assign sys_rd   = bus_re && (dec.tgt == TGT_SYS);
    assign sys_wr   = bus_we && (dec.tgt == TGT_SYS);

    mmio_key_store #(
        .KEY_WORDS (KEY_WORDS),
        .KEY_SEED  (KEY_SEED)
    ) u_key (
        .clk      (clk),
        .rst      (rst),
        .off      (dec.off),
        .take     (key_take),
        .in_range (key_in_range),
        .rdata    (key_rdata)
    );

    mmio_sysctl #(
        .CDI_WORDS (CDI_WORDS)
    ) u_sys (
        .clk      (clk),
        .rst      (rst),
        .off      (dec.off),
        .rd       (sys_rd),
        .wr       (sys_wr),
        .wdata    (bus_wdata),
        .app_mode (app_mode),
        .rdata    (sys_rdata),
        .err      (sys_err)
    );

    always_comb begin
        err_now = acc && (dec.bad
                  || (dec.tgt == TGT_KEY && (bus_we || !key_in_range))
                  || (dec.tgt == TGT_SYS && sys_err));
    end

    genvar g;
    generate
        for (g = 0; g < NSEL; g++) begin : g_sel
            assign sel[g] = acc && !err_now && (dec.tgt == sel_target(g));
        end
        for (g = 0; g < EXT_N; g++) begin : g_ext
            assign ext_word[g] = ext_rdata[g*DW +: DW];
            assign ext_hit[g]  = (dec.tgt == ext_target(g));
        end
    endgenerate

    always_comb begin
        rd_next = '0;
        if (bus_re && !err_now) begin
            for (int i = 0; i < EXT_N; i++) begin
                if (ext_hit[i]) begin
                    rd_next = ext_word[i];
                end
            end
            if (dec.tgt == TGT_KEY) begin
                rd_next = key_rdata;
            end
            if (dec.tgt == TGT_SYS) begin
                rd_next = sys_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            rd_q  <= rd_next;
            err_q <= err_now;
        end
    end

    assign rd_data    = rd_q;
    assign access_err = err_q;

endmodule

// File: rtl/mmio_mode_decoder_checker.sv
module mmio_mode_decoder_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] bus_addr,
    input logic        bus_we,
    input logic        bus_re,
    input logic [7:0]  sel,
    input logic [31:0] rd_data,
    input logic        access_err,
    input logic        app_mode
);
    // R2: at most one destination chosen
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R1: reserved region is always flagged
    a_r1_rsvd_flag: assert property (@(posedge clk) disable iff (rst)
        ((bus_re || bus_we) && bus_addr[31:30] == 2'b10) |=> access_err);

    // R11: no access, no error next cycle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(bus_re || bus_we) |=> !access_err);

    // R3: no read, zero read data next cycle
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (rd_data == 32'h0));

    // R5: application mode is sticky until reset
    a_r5_mode_sticky: assert property (@(posedge clk) disable iff (rst)
        app_mode |=> app_mode);

    // R5: entry only through a write
    a_r5_entry_by_write: assert property (@(posedge clk) disable iff (rst)
        $rose(app_mode) |-> $past(bus_we));

    // R9: key core never selected in application mode
    a_r9_key_hidden: assert property (@(posedge clk) disable iff (rst)
        app_mode |-> !sel[4]);

    // R10: misaligned memory-mapped access selects nothing
    a_r10_misaligned: assert property (@(posedge clk) disable iff (rst)
        ((bus_re || bus_we) && bus_addr[31:30] == 2'b11 && bus_addr[1:0] != 2'b00)
        |-> (sel == 8'h0));

endmodule

bind mmio_mode_decoder mmio_mode_decoder_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .sel        (sel),
    .rd_data    (rd_data),
    .access_err (access_err),
    .app_mode   (app_mode)
);

// File: tb/mmio_mode_decoder_test.sv
module mmio_mode_decoder_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] SEED       = 32'h5A5A_C3C3;

    typedef struct {
        logic [31:0] rd;
        logic        err;
        string       tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [31:0]  bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_re = 1'b0;
    logic [191:0] ext_rdata;
    logic [7:0]   sel;
    logic [31:0]  rd_data;
    logic         access_err;
    logic         app_mode;

    int   checks = 0;
    int   fails  = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < 6; i++) begin : g_ext
        assign ext_rdata[i*32 +: 32] = 32'hA000_0000 + 32'(i) * 32'h111;
    end

    mmio_mode_decoder uut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_re     (bus_re),
        .ext_rdata  (ext_rdata),
        .sel        (sel),
        .rd_data    (rd_data),
        .access_err (access_err),
        .app_mode   (app_mode)
    );

    function automatic logic [31:0] ext_val(input int i);
        return 32'hA000_0000 + 32'(i) * 32'h111;
    endfunction

    function automatic logic [31:0] kword(input int i);
        return SEED ^ (32'(i) * 32'h9E37_79B9);
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares registered outputs one cycle after each access
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " rd_data"}, rd_data, e.rd);
                check({e.tag, " access_err"}, 32'(access_err), 32'(e.err));
            end
        end
    end

    task automatic access(input logic [31:0] a, input logic we,
                          input logic [31:0] wd, input logic re,
                          input logic [7:0] exp_sel, input logic [31:0] exp_rd,
                          input logic exp_err, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = wd;
        bus_re    = re;
        #1;
        check({tag, " sel"}, 32'(sel), 32'(exp_sel));
        e.rd  = exp_rd;
        e.err = exp_err;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_mode(input logic exp, input string tag);
        @(negedge clk);
        check({tag, " app_mode"}, 32'(app_mode), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R12: reset state
        check("R12 reset app_mode", 32'(app_mode), 32'h0);
        check("R12 reset rd_data", rd_data, 32'h0);
        check("R12 reset access_err", 32'(access_err), 32'h0);
        check("R12 reset sel", 32'(sel), 32'h0);

        // R1 regions
        access(32'h0000_0010, 0, 0, 1, 8'h01, ext_val(0), 0, "R1 rom");
        access(32'h4000_0020, 0, 0, 1, 8'h02, ext_val(1), 0, "R1 ram");
        access(32'h8000_0000, 0, 0, 1, 8'h00, 32'h0, 1, "R1 reserved");
        access(32'h0000_0000, 0, 0, 0, 8'h00, 32'h0, 0, "R11 idle");

        // R2 / R3 cores
        access(32'hC000_0004, 0, 0, 1, 8'h04, ext_val(2), 0, "R2 rng");
        access(32'hC100_0000, 0, 0, 1, 8'h08, ext_val(3), 0, "R2 timer");
        access(32'hC300_0008, 0, 0, 1, 8'h20, ext_val(4), 0, "R3 uart");
        access(32'hC400_0000, 0, 0, 1, 8'h40, ext_val(5), 0, "R3 touch");
        access(32'hC500_0000, 0, 0, 1, 8'h00, 32'h0, 1, "R2 unknown core");
        access(32'hC300_0000, 1, 32'h55, 0, 8'h20, 32'h0, 0, "R3 write no read");

        // R4 identity
        access(32'hFF00_0000, 0, 0, 1, 8'h80, 32'h6D74_6131, 0, "R4 id0");
        access(32'hFF00_0004, 0, 0, 1, 8'h80, 32'h6D6B_6466, 0, "R4 id1");
        access(32'hFF00_0008, 0, 0, 1, 8'h80, 32'h1, 0, "R4 ver");
        access(32'hFF00_0000, 1, 32'h1234, 0, 8'h00, 32'h0, 1, "R4 id write");
        access(32'hFF00_0000, 0, 0, 1, 8'h80, 32'h6D74_6131, 0, "R4 id after write");

        // R6 / R7 loader writes
        access(32'hFF00_0014, 1, 32'h4001_0000, 0, 8'h80, 32'h0, 0, "R6 addr write");
        access(32'hFF00_0014, 0, 0, 1, 8'h80, 32'h4001_0000, 0, "R6 addr read");
        access(32'hFF00_0018, 1, 32'h0000_0400, 0, 8'h80, 32'h0, 0, "R6 size write");
        access(32'hFF00_0018, 1, 32'h0000_0800, 1, 8'h80, 32'h0000_0400, 0, "R6 rw same cycle");
        access(32'hFF00_0018, 0, 0, 1, 8'h80, 32'h0000_0800, 0, "R6 size after rw");
        access(32'hFF00_004C, 1, 32'hCAFE_F00D, 0, 8'h80, 32'h0, 0, "R7 cdi write");
        access(32'hFF00_004C, 0, 0, 1, 8'h80, 32'hCAFE_F00D, 0, "R7 cdi read");
        access(32'hFF00_0048, 0, 0, 1, 8'h80, 32'h0, 0, "R7 cdi other word");

        // R8 key read-once
        access(32'hC200_0000, 0, 0, 1, 8'h10, kword(0), 0, "R8 key0 first");
        access(32'hC200_0000, 0, 0, 1, 8'h10, 32'h0, 0, "R8 key0 second");
        access(32'hC200_0004, 0, 0, 1, 8'h10, kword(1), 0, "R8 key1");
        access(32'hC200_0008, 1, 32'h1, 0, 8'h00, 32'h0, 1, "R8 key write");
        access(32'hC200_0020, 0, 0, 1, 8'h00, 32'h0, 1, "R8 key out of range");
        access(32'hC200_0009, 0, 0, 1, 8'h00, 32'h0, 1, "R10 key misaligned");
        access(32'hC200_0008, 0, 0, 1, 8'h10, kword(2), 0, "R10 key2 not consumed");

        // R10 misaligned mode switch
        access(32'hFF00_0011, 1, 32'h1, 0, 8'h00, 32'h0, 1, "R10 misaligned switch");
        check_mode(1'b0, "R10 mode unchanged");

        // R12 reset restores key
        do_reset();
        access(32'hC200_0000, 0, 0, 1, 8'h10, kword(0), 0, "R12 key0 after reset");
        access(32'hFF00_0014, 0, 0, 1, 8'h80, 32'h0, 0, "R12 addr cleared");
        access(32'hFF00_0018, 1, 32'h0000_0200, 0, 8'h80, 32'h0, 0, "R6 size write again");

        // R5 mode switch
        access(32'hFF00_0010, 1, 32'h0, 0, 8'h80, 32'h0, 0, "R5 zero write");
        check_mode(1'b0, "R5 zero write");
        access(32'hFF00_0010, 0, 0, 1, 8'h00, 32'h0, 1, "R5 switch read");
        access(32'hFF00_0010, 1, 32'h5, 0, 8'h80, 32'h0, 0, "R5 switch write");
        check_mode(1'b1, "R5 entered app");

        // Application mode
        access(32'hFF00_0018, 0, 0, 1, 8'h80, 32'h0000_0200, 0, "R6 app read size");
        access(32'hFF00_0018, 1, 32'h9999, 0, 8'h00, 32'h0, 1, "R6 app write size");
        access(32'hFF00_0018, 0, 0, 1, 8'h80, 32'h0000_0200, 0, "R6 size unchanged");
        access(32'hFF00_0040, 1, 32'h7777, 0, 8'h00, 32'h0, 1, "R7 app cdi write");
        access(32'hFF00_0040, 0, 0, 1, 8'h80, 32'h0, 0, "R7 cdi unchanged");
        access(32'hC200_0004, 0, 0, 1, 8'h00, 32'h0, 1, "R9 key hidden");
        access(32'hFF00_0010, 1, 32'h0, 0, 8'h00, 32'h0, 1, "R5 app switch write");
        check_mode(1'b1, "R5 still app");
        access(32'hFF00_0004, 0, 0, 1, 8'h80, 32'h6D6B_6466, 0, "R4 id in app");
        access(32'h4000_0000, 0, 0, 1, 8'h02, ext_val(1), 0, "R1 ram in app");

        // R12 reset leaves app mode; key1 readable
        do_reset();
        check("R12 app_mode cleared", 32'(app_mode), 32'h0);
        access(32'hC200_0004, 0, 0, 1, 8'h10, kword(1), 0, "R12 key1 after reset");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule